// File: doc/BRIEF.md
# Disk Controller Threshold Data FIFO

This block is the data buffer between a host bus and the bit serializer of a floppy-style disk controller. It holds up to 16 bytes. It follows the command flow through three phases: command, execution and result. While the command bytes are exchanged the buffer stays out of the path, and it is emptied at the moment execution begins. During a transfer it raises a service request towards the host or a DMA engine whenever enough room (writes) or enough data (reads) has built up. The trigger level is programmable.

A byte-slot timer paces the disk side. It is derived from the reference clock and scaled by the selected data rate. On a write, one byte leaves the buffer per slot, and a CRC-16 follows once the programmed sector length has been sent. If the host falls behind (underrun), the rest of the sector goes out as zero bytes, still followed by a valid CRC. On a read, one disk byte enters the buffer per slot. If the buffer is full at a slot (overrun), the transfer stops, and the result phase waits until the host has emptied the buffer.

Top module: `fdc_xfer_fifo`

## Requirements
- R1: A `cmd_start_i` pulse, in any phase, moves the block to the command phase (`phase_o` = 0), empties the buffer and clears `err_o`. In the command phase, host writes and reads leave `fifo_count_o` at 0, and `dma_req_o` stays low.
- R2: An `exec_start_i` pulse in the command phase enters the execution phase (`phase_o` = 1) with an empty buffer. It latches the direction (`dir_write_i` = 1 for a disk write), the sector length and a restart of the slot timer.
- R3: The buffer holds at most `DEPTH` (16) bytes and returns them in arrival order. A push into a full buffer is dropped.
- R4: During a write transfer with no error, `dma_req_o` is high exactly when the free space (16 − count) is at least the threshold. A threshold of 0 counts as 1.
- R5: During a read transfer, `dma_req_o` is high when the count is at least the threshold (0 counts as 1). After the last disk byte, or after an overrun, it is high whenever the buffer is not empty.
- R6: Disk byte slots recur every `BASE_TICKS`×4 cycles for `rate_sel_i` = 0 (500 kbps), ×2 for 1 (1 Mbps), ×1 for 2 (2 Mbps) and ×4 for 3. The first slot falls that many cycles after the execution-start edge.
- R7: On a write, each slot sends one byte on `disk_byte_o` with a one-cycle `disk_valid_o`, in buffer order. After `sector_len_i` data bytes come the two CRC bytes. The block then enters the result phase (`phase_o` = 2) at the edge that sends the last CRC byte.
- R8: The CRC is CRC-16 with polynomial 0x1021, preset to 0xFFFF, shifted MSB first over all sent data bytes (padding included), and sent high byte first.
- R9: A write slot that finds the buffer empty sets `err_o[0]` (underrun) and sends 0x00. From then on every remaining data byte of the sector is 0x00, host writes are ignored and `dma_req_o` stays low. The CRC still follows.
- R10: A read slot that finds the buffer full sets `err_o[1]` (overrun) and drops that byte. No further disk byte is taken.
- R11: A read transfer enters the result phase only after the host has emptied the buffer, one cycle after the count reaches 0.
- R12: Once set, an `err_o` bit holds until the next `cmd_start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Pulse: a new command begins |
| exec_start_i | input | 1 | Pulse: execution phase begins |
| dir_write_i | input | 1 | Transfer direction, 1 = write to disk |
| thresh_i | input | $clog2(DEPTH) | Service threshold, 0 acts as 1 |
| rate_sel_i | input | 2 | Data rate select |
| sector_len_i | input | SECT_W | Data bytes per sector (at least 1) |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 8 | Head byte of the buffer |
| disk_byte_i | input | 8 | Byte from the serializer, sampled at a read slot |
| disk_slot_o | output | 1 | Byte slot strobe to the serializer |
| disk_byte_o | output | 8 | Byte to the serializer |
| disk_valid_o | output | 1 | `disk_byte_o` valid, one cycle |
| dma_req_o | output | 1 | Service request |
| phase_o | output | 2 | 0 command, 1 execution, 2 result |
| err_o | output | 2 | bit0 underrun, bit1 overrun |
| fifo_count_o | output | $clog2(DEPTH+1) | Bytes held |

## Verification
The count, the phase and the error flags change at the clock edge that takes a strobe, so the bench reads them at the falling edge that follows. The request follows the registered count in the same cycle. A disk slot completes at the edge exactly one slot time after the execution-start edge. The byte it writes shows on `disk_valid_o` from that edge, and the bench records the cycle number of each captured byte, comparing it with the start cycle plus whole slot times. The read result phase is due one cycle after the last host read has emptied the buffer, and the bench samples it at that falling edge.

// File: rtl/fdc_fifo_pkg.sv
package fdc_fifo_pkg;

  typedef enum logic [1:0] {
    PH_CMD    = 2'd0,
    PH_EXEC   = 2'd1,
    PH_RESULT = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    S_CMD, S_XFER, S_CRC_HI, S_CRC_LO, S_DRAIN, S_RES
  } state_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  function automatic logic [15:0] crc16_step(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  // slot length = base << shift
  function automatic logic [1:0] rate_shift(logic [1:0] sel);
    case (sel)
      2'd1:    return 2'd1;
      2'd2:    return 2'd0;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/fdc_byte_fifo.sv
module fdc_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

endmodule

// File: rtl/fdc_byte_timer.sv
module fdc_byte_timer
  import fdc_fifo_pkg::*;
#(
  parameter int BASE_TICKS = 4,
  localparam int CW = $clog2(4 * BASE_TICKS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       run_i,
  input  logic [1:0] rate_sel_i,
  output logic       tick_o
);

  logic [CW-1:0] cnt_q, limit;

  assign limit  = CW'(BASE_TICKS) << rate_shift(rate_sel_i);
  // >= guards against a rate change in mid-slot
  assign tick_o = run_i && (cnt_q >= limit - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= tick_o ? '0 : cnt_q + CW'(1);
  end

endmodule

// File: rtl/fdc_crc16_gen.sv
module fdc_crc16_gen
  import fdc_fifo_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        preset_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);

  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       crc_q <= CRC_SEED;
    else if (preset_i) crc_q <= CRC_SEED;
    else if (en_i)     crc_q <= crc16_step(crc_q, data_i);
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/fdc_xfer_fifo.sv
module fdc_xfer_fifo
  import fdc_fifo_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int SECT_W     = 10,
  parameter int BASE_TICKS = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic              exec_start_i,
  input  logic              dir_write_i,
  input  logic [TW-1:0]     thresh_i,
  input  logic [1:0]        rate_sel_i,
  input  logic [SECT_W-1:0] sector_len_i,
  input  logic              host_wr_i,
  input  logic [7:0]        host_wdata_i,
  input  logic              host_rd_i,
  output logic [7:0]        host_rdata_o,
  input  logic [7:0]        disk_byte_i,
  output logic              disk_slot_o,
  output logic [7:0]        disk_byte_o,
  output logic              disk_valid_o,
  output logic              dma_req_o,
  output logic [1:0]        phase_o,
  output logic [1:0]        err_o,
  output logic [CW-1:0]     fifo_count_o
);

  state_e            state_q;
  logic              dir_q;
  logic [SECT_W-1:0] len_q, done_q;
  logic [1:0]        err_q;
  logic [7:0]        dbyte_q;
  logic              dvalid_q;

  logic tick, active, xfer, drain, exec_go, flush;
  logic wr_slot, rd_slot, host_push, disk_push, host_pop, disk_pop;
  logic full, empty, last;
  logic [7:0]    fifo_rdata, tx_byte;
  logic [CW-1:0] count, thr_eff, free;
  logic [15:0]   crc;

  assign xfer    = (state_q == S_XFER);
  assign drain   = (state_q == S_DRAIN);
  assign active  = xfer || (state_q == S_CRC_HI) || (state_q == S_CRC_LO);
  assign exec_go = exec_start_i && !cmd_start_i && (state_q == S_CMD);
  assign flush   = cmd_start_i || exec_go;

  assign wr_slot   = tick && xfer && dir_q;
  assign rd_slot   = tick && xfer && !dir_q;
  assign host_push = xfer && dir_q && (err_q == '0) && host_wr_i;
  assign disk_push = rd_slot && !full;
  assign host_pop  = (xfer || drain) && !dir_q && host_rd_i;
  assign disk_pop  = wr_slot && !err_q[0] && !empty;
  assign tx_byte   = disk_pop ? fifo_rdata : 8'h00;
  assign last      = (done_q == len_q - SECT_W'(1));

  fdc_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (host_push || disk_push),
    .wdata_i (dir_q ? host_wdata_i : disk_byte_i),
    .pop_i   (host_pop || disk_pop),
    .rdata_o (fifo_rdata),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  fdc_byte_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (exec_go),
    .run_i      (active),
    .rate_sel_i (rate_sel_i),
    .tick_o     (tick)
  );

  fdc_crc16_gen u_crc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .preset_i (exec_go),
    .en_i     (wr_slot),
    .data_i   (tx_byte),
    .crc_o    (crc)
  );

  assign thr_eff = (thresh_i == '0) ? CW'(1) : CW'(thresh_i);
  assign free    = CW'(DEPTH) - count;

  always_comb begin
    if (dir_q) dma_req_o = xfer && (err_q == '0) && (free >= thr_eff);
    else       dma_req_o = (xfer && (count >= thr_eff)) || (drain && !empty);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_CMD;
      dir_q   <= 1'b0;
      len_q   <= '0;
      done_q  <= '0;
      err_q   <= '0;
    end else if (cmd_start_i) begin
      state_q <= S_CMD;
      err_q   <= '0;
    end else begin
      case (state_q)
        S_CMD: if (exec_start_i) begin
          state_q <= S_XFER;
          dir_q   <= dir_write_i;
          len_q   <= sector_len_i;
          done_q  <= '0;
        end
        S_XFER: begin
          if (wr_slot) begin
            done_q <= done_q + SECT_W'(1);
            if (!disk_pop) err_q[0] <= 1'b1;
            if (last) state_q <= S_CRC_HI;
          end
          if (rd_slot) begin
            if (full) begin
              err_q[1] <= 1'b1;
              state_q  <= S_DRAIN;
            end else begin
              done_q <= done_q + SECT_W'(1);
              if (last) state_q <= S_DRAIN;
            end
          end
        end
        S_CRC_HI: if (tick) state_q <= S_CRC_LO;
        S_CRC_LO: if (tick) state_q <= S_RES;
        S_DRAIN:  if (empty) state_q <= S_RES;
        default:  state_q <= state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvalid_q <= 1'b0;
      dbyte_q  <= '0;
    end else begin
      dvalid_q <= !cmd_start_i && tick && active && dir_q;
      if (tick && active && dir_q) begin
        case (state_q)
          S_CRC_HI: dbyte_q <= crc[15:8];
          S_CRC_LO: dbyte_q <= crc[7:0];
          default:  dbyte_q <= tx_byte;
        endcase
      end
    end
  end

  always_comb begin
    case (state_q)
      S_CMD:   phase_o = PH_CMD;
      S_RES:   phase_o = PH_RESULT;
      default: phase_o = PH_EXEC;
    endcase
  end

  assign host_rdata_o = fifo_rdata;
  assign disk_slot_o  = tick;
  assign disk_byte_o  = dbyte_q;
  assign disk_valid_o = dvalid_q;
  assign err_o        = err_q;
  assign fifo_count_o = count;

endmodule

// File: rtl/fdc_xfer_fifo_chk.sv
module fdc_xfer_fifo_chk
  import fdc_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_start_i,
  input logic          exec_start_i,
  input logic          disk_slot_o,
  input logic          disk_valid_o,
  input logic          dma_req_o,
  input logic [1:0]    phase_o,
  input logic [1:0]    err_o,
  input logic [CW-1:0] fifo_count_o,
  input logic          dir_q
);

  p_cmd_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_i |=> (phase_o == PH_CMD && fifo_count_o == '0 && err_o == '0));

  p_cmd_no_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_CMD) |-> !dma_req_o);

  p_exec_flush_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_start_i && !cmd_start_i && phase_o == PH_CMD)
      |=> (phase_o == PH_EXEC && fifo_count_o == '0));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_count_o <= CW'(DEPTH));

  p_valid_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disk_valid_o |-> dir_q);

  p_underrun_noreq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o[0] |-> !dma_req_o);

  p_overrun_halt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o[1] |-> !disk_slot_o);

  p_drain_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_EXEC && !dir_q && !cmd_start_i)
      |=> (phase_o == PH_EXEC || fifo_count_o == '0));

  p_under_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o[0] && !cmd_start_i) |=> err_o[0]);

  p_over_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o[1] && !cmd_start_i) |=> err_o[1]);

endmodule

bind fdc_xfer_fifo fdc_xfer_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_start_i  (cmd_start_i),
  .exec_start_i (exec_start_i),
  .disk_slot_o  (disk_slot_o),
  .disk_valid_o (disk_valid_o),
  .dma_req_o    (dma_req_o),
  .phase_o      (phase_o),
  .err_o        (err_o),
  .fifo_count_o (fifo_count_o),
  .dir_q        (dir_q)
);

// File: tb/fdc_xfer_fifo_test.sv
module fdc_xfer_fifo_test;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_start_i = 1'b0;
  logic       exec_start_i = 1'b0;
  logic       dir_write_i = 1'b0;
  logic [3:0] thresh_i = '0;
  logic [1:0] rate_sel_i = '0;
  logic [9:0] sector_len_i = '0;
  logic       host_wr_i = 1'b0;
  logic [7:0] host_wdata_i = '0;
  logic       host_rd_i = 1'b0;
  logic [7:0] host_rdata_o;
  logic [7:0] disk_byte_i = 8'h30;
  logic       disk_slot_o;
  logic [7:0] disk_byte_o;
  logic       disk_valid_o;
  logic       dma_req_o;
  logic [1:0] phase_o;
  logic [1:0] err_o;
  logic [4:0] fifo_count_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0] cap_b [256];
  int         cap_c [256];
  int         cap_n = 0;
  int         slot_n = 0;

  fdc_xfer_fifo uut (
    .clk_i, .rst_ni, .cmd_start_i, .exec_start_i, .dir_write_i, .thresh_i,
    .rate_sel_i, .sector_len_i, .host_wr_i, .host_wdata_i, .host_rd_i,
    .host_rdata_o, .disk_byte_i, .disk_slot_o, .disk_byte_o, .disk_valid_o,
    .dma_req_o, .phase_o, .err_o, .fifo_count_o
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // capture bytes sent to the serializer
  always @(negedge clk_i) begin
    if (disk_valid_o && cap_n < 256) begin
      cap_b[cap_n] = disk_byte_o;
      cap_c[cap_n] = cyc;
      cap_n = cap_n + 1;
    end
  end

  // serializer model for reads: next byte after every read slot
  initial begin
    bit pend;
    pend = 1'b0;
    forever begin
      @(negedge clk_i);
      if (pend) begin
        slot_n = slot_n + 1;
        disk_byte_i = 8'h30 + slot_n[7:0];
        pend = 1'b0;
      end
      if (disk_slot_o && !dir_write_i) pend = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      if (r[15] ^ d[b]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic int slot_len(input logic [1:0] r);
    return (r == 2'd1) ? 8 : (r == 2'd2) ? 4 : 16;
  endfunction

  task automatic do_cmd();
    @(negedge clk_i); cmd_start_i = 1'b1;
    @(negedge clk_i); cmd_start_i = 1'b0;
  endtask

  task automatic do_exec(output int c0);
    exec_start_i = 1'b1;
    @(negedge clk_i); exec_start_i = 1'b0;
    c0 = cyc;
  endtask

  task automatic t_reset();
    chk(phase_o == 2'd0, "R1 reset phase", phase_o, 0);
    chk(fifo_count_o == 0, "R1 reset count", fifo_count_o, 0);
    chk(err_o == 0 && !dma_req_o, "R1 reset err/req", {err_o, dma_req_o}, 0);
  endtask

  task automatic t_cmd_ignore();
    int c0;
    do_cmd();
    dir_write_i = 1'b1; thresh_i = 4'd1;
    host_wr_i = 1'b1; host_wdata_i = 8'hEE;
    repeat (3) @(negedge clk_i);
    host_wr_i = 1'b0;
    chk(fifo_count_o == 0, "R1 write in cmd phase", fifo_count_o, 0);
    chk(!dma_req_o, "R1 req in cmd phase", dma_req_o, 0);
    do_exec(c0);
    chk(phase_o == 2'd1, "R2 exec phase", phase_o, 1);
    chk(fifo_count_o == 0, "R2 exec flush", fifo_count_o, 0);
  endtask

  task automatic run_write(input logic [1:0] rate, input int len, input int nsup,
                           input int thr, input logic [7:0] seed);
    int c0, bt, base, te, w;
    bit under;
    logic [7:0]  exp_b [64];
    logic [15:0] crc;
    bt = slot_len(rate);
    te = (thr == 0) ? 1 : thr;
    under = (nsup < len);
    do_cmd();
    thresh_i = thr[3:0]; rate_sel_i = rate; sector_len_i = len[9:0];
    dir_write_i = 1'b1;
    base = cap_n;
    do_exec(c0);
    chk(dma_req_o == (16 >= te), "R4 req empty", dma_req_o, (16 >= te));
    for (int k = 0; k < nsup; k++) begin
      host_wr_i = 1'b1; host_wdata_i = seed + k[7:0];
      @(negedge clk_i);
      host_wr_i = 1'b0;
      chk(fifo_count_o == k + 1, "R3 fill count", fifo_count_o, k + 1);
      chk(dma_req_o == ((15 - k) >= te), "R4 req level", dma_req_o, ((15 - k) >= te));
    end
    if (under) begin
      w = 0;
      while (!err_o[0] && w < 500) begin @(negedge clk_i); w++; end
      chk(err_o[0], "R9 underrun flag", err_o, 1);
      host_wr_i = 1'b1; host_wdata_i = 8'h5A;
      @(negedge clk_i);
      host_wr_i = 1'b0;
      chk(fifo_count_o == 0, "R9 write ignored", fifo_count_o, 0);
      chk(!dma_req_o, "R9 no req", dma_req_o, 0);
    end
    w = 0;
    while (cap_n < base + len + 2 && w < 2000) begin @(negedge clk_i); w++; end
    crc = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      exp_b[i] = (i < nsup) ? seed + i[7:0] : 8'h00;
      crc = ref_crc(crc, exp_b[i]);
    end
    exp_b[len] = crc[15:8];
    exp_b[len + 1] = crc[7:0];
    for (int i = 0; i < len + 2; i++)
      chk(cap_b[base + i] == exp_b[i],
          (i >= len) ? "R8 crc byte" : (i >= nsup) ? "R9 pad byte" : "R7 data byte",
          cap_b[base + i], exp_b[i]);
    chk(cap_c[base] == c0 + bt, "R6 first slot", cap_c[base] - c0, bt);
    chk(cap_c[base + len + 1] == c0 + (len + 2) * bt, "R6 slot spacing",
        cap_c[base + len + 1] - c0, (len + 2) * bt);
    chk(cap_n == base + len + 2, "R7 byte count", cap_n - base, len + 2);
    chk(phase_o == 2'd2, "R7 result phase", phase_o, 2);
    chk(err_o == {1'b0, under}, "R9 err status", err_o, {1'b0, under});
  endtask

  task automatic t_read_normal();
    int c0, base, w;
    do_cmd();
    thresh_i = 4'd4; rate_sel_i = 2'd2; sector_len_i = 10'd6;
    dir_write_i = 1'b0;
    base = slot_n;
    do_exec(c0);
    w = 0;
    while (fifo_count_o != 3 && w < 200) begin @(negedge clk_i); w++; end
    chk(!dma_req_o, "R5 req below thr", dma_req_o, 0);
    while (fifo_count_o != 4 && w < 200) begin @(negedge clk_i); w++; end
    chk(dma_req_o, "R5 req at thr", dma_req_o, 1);
    while (fifo_count_o != 6 && w < 200) begin @(negedge clk_i); w++; end
    repeat (12) @(negedge clk_i);
    chk(fifo_count_o == 6, "R11 sector end", fifo_count_o, 6);
    chk(phase_o == 2'd1, "R11 held in exec", phase_o, 1);
    for (int i = 0; i < 6; i++) begin
      if (i == 5) begin
        chk(dma_req_o, "R5 drain req", dma_req_o, 1);
        chk(phase_o == 2'd1, "R11 not yet result", phase_o, 1);
      end
      chk(host_rdata_o == 8'h30 + base[7:0] + i[7:0], "R3 read order",
          host_rdata_o, 8'h30 + base[7:0] + i[7:0]);
      host_rd_i = 1'b1;
      @(negedge clk_i);
      host_rd_i = 1'b0;
    end
    chk(fifo_count_o == 0 && phase_o == 2'd1, "R11 empty then result",
        {fifo_count_o, phase_o}, 1);
    @(negedge clk_i);
    chk(phase_o == 2'd2, "R11 result phase", phase_o, 2);
    chk(err_o == 0, "R10 no overrun", err_o, 0);
  endtask

  task automatic t_overrun();
    int c0, base, w;
    do_cmd();
    thresh_i = 4'd0; rate_sel_i = 2'd2; sector_len_i = 10'd40;
    dir_write_i = 1'b0;
    base = slot_n;
    do_exec(c0);
    chk(!dma_req_o, "R5 thr0 empty", dma_req_o, 0);
    w = 0;
    while (fifo_count_o == 0 && w < 50) begin @(negedge clk_i); w++; end
    chk(dma_req_o && fifo_count_o == 1, "R5 thr0 one byte", {fifo_count_o, dma_req_o}, 3);
    while (!err_o[1] && w < 400) begin @(negedge clk_i); w++; end
    chk(err_o == 2'b10, "R10 overrun flag", err_o, 2);
    chk(fifo_count_o == 16, "R3 full", fifo_count_o, 16);
    repeat (20) @(negedge clk_i);
    chk(fifo_count_o == 16, "R10 no more bytes", fifo_count_o, 16);
    chk(err_o[1], "R12 overrun held", err_o, 2);
    chk(phase_o == 2'd1, "R11 waits for drain", phase_o, 1);
    for (int i = 0; i < 16; i++) begin
      chk(host_rdata_o == 8'h30 + base[7:0] + i[7:0], "R10 kept bytes",
          host_rdata_o, 8'h30 + base[7:0] + i[7:0]);
      host_rd_i = 1'b1;
      @(negedge clk_i);
      host_rd_i = 1'b0;
    end
    @(negedge clk_i);
    chk(phase_o == 2'd2, "R11 result after drain", phase_o, 2);
    chk(err_o[1], "R12 held in result", err_o, 2);
    do_cmd();
    chk(err_o == 0 && phase_o == 2'd0 && fifo_count_o == 0, "R12 cleared by cmd",
        {err_o, phase_o, fifo_count_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_cmd_ignore();
    run_write(2'd0, 4, 9, 8, 8'hA1);
    run_write(2'd2, 5, 2, 15, 8'h11);
    run_write(2'd1, 3, 3, 0, 8'hC4);
    run_write(2'd3, 2, 2, 13, 8'h7E);
    t_read_normal();
    t_overrun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule